// File: doc/BRIEF.md
# Programmable Baud Tick Generator

This block turns a fast system clock into a stream of single-cycle enable pulses at sixteen times a chosen serial bit rate, for an oversampling UART receiver and transmitter. A single configuration word, written in one cycle over a plain write strobe and data bus, sets the rate. The word holds a down-counter reload value (the divisor minus one), a bit that adds a fixed divide-by-16 prescaler in front of that counter, a run-enable bit and a soft-reset bit.

A package function builds the configuration word from the system clock frequency and the wanted baud rate. It rounds the divisor to the nearest integer. When the divisor is too large for the counter field, it switches the prescaler on and divides the divisor by 16 again, also rounding. Each write restarts both counters from their reload values, so the first pulse after a write lands at a known time.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset `tick_o` is low and stays low until a configuration word with the enable bit set and the soft-reset bit clear is written.
- R2: A configuration word whose enable bit (bit 13) is 0 produces no tick, whatever its other fields hold.
- R3: A configuration word whose soft-reset bit (bit 14) is 1 produces no tick, even with the enable bit set. A later word with the bit clear starts the generator from its reload values.
- R4: With the prescale bit (bit 0) clear and divide field D in bits 12:1, ticks recur every D+1 cycles and each is one cycle wide. With D = 0, `tick_o` is high on every cycle.
- R5: With the prescale bit set, ticks recur every 16*(D+1) cycles.
- R6: With a write taken on clock edge E and period P (R4 or R5), the first tick is visible in the cycle that follows edge E+P.
- R7: A new write while the generator runs discards the old count, and the timing of R6 applies from the new write.
- R8: `baud_pkg::calc_cfg_word` returns the enable bit together with (N-1) in bits 12:1 and the prescale bit clear, where N = (f/16 + b/2) / b in integer arithmetic, f is the system clock and b the baud rate, whenever N <= 4096.
- R9: When N > 4096, `calc_cfg_word` sets the prescale bit and stores ((N+8)/16) - 1 in bits 12:1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 15 | Configuration word: bit 0 prescale, bits 12:1 divisor minus one, bit 13 enable, bit 14 soft reset |
| tick_o | output | 1 | One-cycle enable pulse at 16 times the bit rate |

## Verification
The hardest case to reach is the prescaled path at a real baud rate. A divisor large enough to set the prescale bit gives periods of thousands of cycles, so a long run is needed to see it. The bench takes the word that the helper returns for a low baud rate and runs the generator for two full periods of it. It also sweeps small divide values with the prescaler on, so the gating shows in short runs. A second write is issued part way through a period to show that the old count is thrown away.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DIV_W_DEF = 12;
    localparam int PRE_W_DEF = 4;
    localparam int CFG_W_DEF = DIV_W_DEF + 3;

    // Configuration word builder: rounded divisor, prescaler when it overflows.
    function automatic logic [CFG_W_DEF-1:0] calc_cfg_word(input longint sys_hz, input longint baud);
        longint n;
        logic   pre;
        logic [CFG_W_DEF-1:0] w;
        n   = ((sys_hz / 16) + (baud / 2)) / baud;
        pre = 1'b0;
        if (n > (longint'(1) << DIV_W_DEF)) begin
            pre = 1'b1;
            n   = (n + 8) / 16;
        end
        w = '0;
        w[DIV_W_DEF+1]   = 1'b1;
        w[DIV_W_DEF:1]   = DIV_W_DEF'(n - 1);
        w[0]             = pre;
        return w;
    endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
    parameter int DIV_W = baud_pkg::DIV_W_DEF,
    localparam int CFG_W = DIV_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic             q_pre,
    output logic             q_en,
    output logic             q_srst,
    output logic [DIV_W-1:0] nx_div
);
    typedef struct packed {
        logic [CFG_W-1:0] word;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.word = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_pre  = st_q.word[0];
    assign q_en   = st_q.word[DIV_W+1];
    assign q_srst = st_q.word[DIV_W+2];
    assign nx_div = st_d.word[DIV_W:1];

    // R7: a write is taken whole on the next edge
    a_r7_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> st_q.word == $past(wdata));
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int PRE_W = baud_pkg::PRE_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_pre,
    output logic step
);
    localparam logic [PRE_W-1:0] PRE_TOP = '1;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (!run || !use_pre) begin
            st_d.cnt = PRE_TOP;
            step     = run;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = PRE_TOP;
            step     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: PRE_TOP};
        else        st_q <= st_d;
    end

    // R5: a prescaled step never repeats on the following cycle
    a_r5_step_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        (run && use_pre && $past(run && use_pre && step)) |-> !step);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DIV_W = baud_pkg::DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!run) begin
            st_d.cnt = reload;
        end else if (step) begin
            if (st_q.cnt == '0) begin
                st_d.cnt  = reload;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R2: a held generator gives no tick on the next cycle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);
    // R4: a tick only follows a counted step
    a_r4_tick_from_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(run && step));
    // R4: a step above zero does not tick
    a_r4_no_early_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && st_q.cnt != '0) |=> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int DIV_W = baud_pkg::DIV_W_DEF,
    parameter int PRE_W = baud_pkg::PRE_W_DEF,
    localparam int CFG_W = DIV_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             tick_o
);
    logic             q_pre, q_en, q_srst;
    logic [DIV_W-1:0] nx_div;
    logic             run, step;

    baud_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .q_pre(q_pre), .q_en(q_en), .q_srst(q_srst), .nx_div(nx_div)
    );

    // a write cycle restarts both counters from their reload values
    assign run = q_en && !q_srst && !cfg_we;

    baud_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .use_pre(q_pre), .step(step)
    );

    baud_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .step(step),
        .reload(nx_div), .tick(tick_o)
    );

    // R3: soft reset silences the output
    a_r3_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q_srst) && q_srst |-> !tick_o);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic        tick_o;
    int          n_run = 0;
    int          n_fail = 0;

    baud_tick_gen u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
                         .cfg_wdata(cfg_wdata), .tick_o(tick_o));

    always #5 clk = ~clk;

    function automatic logic [14:0] mk(input bit srst, input bit en, input int d, input bit pre);
        logic [14:0] w;
        w = '0;
        w[14] = srst; w[13] = en; w[12:1] = 12'(d); w[0] = pre;
        return w;
    endfunction

    task automatic wr(input logic [14:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // after a write, watch n cycles; tick expected when k is a multiple of p (p=0: never)
    task automatic watch(input int p, input int n, input string req, input int tag);
        int bad = 0;
        int first_k = -1;
        logic first_v = 1'b0;
        for (int k = 1; k <= n; k++) begin
            logic exp;
            @(posedge clk);
            @(negedge clk);
            exp = (p != 0) && (k % p == 0);
            if (tick_o !== exp && bad == 0) begin first_k = k; first_v = tick_o; end
            if (tick_o !== exp) bad++;
        end
        n_run++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s case %0d: cycle %0d tick=%b expected %b (%0d mismatches)",
                     req, tag, first_k, first_v, !first_v, bad);
        end
    endtask

    task automatic chk_word(input logic [14:0] act, input logic [14:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: word %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, no ticks
        n_run++;
        if (tick_o !== 1'b0) begin n_fail++; $display("FAIL R1: tick=%b expected 0", tick_o); end
        rst_n = 1'b1;
        watch(0, 40, "R1", 0);

        // R2: enable clear, various fields
        wr(mk(0, 0, 3, 0));  watch(0, 60, "R2", 1);
        wr(mk(0, 0, 0, 1));  watch(0, 60, "R2", 2);

        // R3: soft reset with enable set, then release
        wr(mk(1, 1, 2, 0));  watch(0, 60, "R3", 1);
        wr(mk(1, 1, 0, 1));  watch(0, 60, "R3", 2);
        wr(mk(0, 1, 4, 0));  watch(5, 30, "R3", 3);

        // R4 / R6: sweep without prescaler
        for (int d = 0; d < 24; d++) begin
            wr(mk(0, 1, d, 0));
            watch(d + 1, 3 * (d + 1) + 2, "R4", d);
        end
        // R5 / R6: sweep with prescaler
        for (int d = 0; d < 8; d++) begin
            wr(mk(0, 1, d, 1));
            watch(16 * (d + 1), 3 * 16 * (d + 1) + 2, "R5", d);
        end

        // R7: rewrite mid-period discards the old count
        wr(mk(0, 1, 30, 0));
        repeat (17) @(posedge clk);
        wr(mk(0, 1, 6, 0));  watch(7, 30, "R7", 1);
        wr(mk(0, 1, 9, 1));
        repeat (50) @(posedge clk);
        wr(mk(0, 1, 2, 0));  watch(3, 20, "R7", 2);

        // R8 / R9: helper values at a 100 MHz system clock
        chk_word(baud_pkg::calc_cfg_word(100_000_000, 9600),   15'h2514, "R8 9600");
        chk_word(baud_pkg::calc_cfg_word(100_000_000, 115200), 15'h206A, "R8 115200");
        chk_word(baud_pkg::calc_cfg_word(100_000_000, 1200),   15'h228B, "R9 1200");
        // R8: helper word drives the generator at 54 cycles per tick
        wr(baud_pkg::calc_cfg_word(100_000_000, 115200)); watch(54, 170, "R8", 3);
        // R9: prescaled word, 16*326 cycles per tick
        wr(baud_pkg::calc_cfg_word(100_000_000, 1200));   watch(5216, 2 * 5216 + 4, "R9", 4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule